// File: doc/BRIEF.md
# Pipelined ADC Correction Aligner

This block is the digital back end of a pipelined analog-to-digital converter. A chain of identical subconverter stages, followed by a final flash stage, each hands over a 2-bit raw code for every analog sample. Neighbouring stages run on opposite clock phases, so the codes for one sample arrive spread out in half-clock steps. The block captures each code on the edge where it becomes valid and delays the early codes until the whole set for one sample is present. It then adds the codes with one bit of overlap between neighbours, which lets the redundant bit absorb comparator error. The sum is clamped into an 8-bit offset-binary word and registered at the output.

A single instance serves several channels that share one sampling clock, for example the in-phase and quadrature paths of a demodulator. The converter front end raises `samp_vld` in the cycle before the rising edge that takes an analog sample. Once the pipeline is full, the block delivers one corrected word per clock, each a fixed number of clocks after its sample.

Top module: `adc_pipe_corr`

## Requirements
- R1: Number the stages from the input, stage 0 first, with the flash stage last as index NSTG. The code of stage k for a sample is captured (k+1)/2 clocks after the rising edge at which `samp_vld` was taken high. An even k therefore lands on a falling edge and an odd k on a rising edge. The flash code lands on the rising edge 4 clocks after the sample when NSTG = 7.
- R2: Each channel's word is the clamped value of S − 1. Here S = Σ d_k·2^(NSTG−1−k) over the stages plus the flash code. Every 2-bit field is read as an unsigned value from 0 to 3.
- R3: The word for a sample taken at rising edge n appears on `data_out` right after rising edge n+6. A new word can follow on every clock after that.
- R4: A result below zero gives 0x00 and a result above 255 gives 0xFF, with no wrap-around. A result of exactly 255 passes through unchanged.
- R5: Stage codes of 1 with a flash code of 2 (mid-scale) give 0x80. Stage codes of 0 with a flash code of 0 give 0x00. Stage codes of 2 with a flash code of 3 give 0xFF.
- R6: `data_vld` after rising edge n+6 equals the value of `samp_vld` taken at edge n, provided no reset was taken in between.
- R7: While `data_vld` is low, `data_out` keeps its previous value.
- R8: A synchronous, active-high `rst` clears `data_out` to 0, drives `data_vld` low and empties all alignment registers. `data_vld` stays low for at least 6 clocks after `rst` is released.
- R9: Channels are independent. Channel c uses field c of `stg_code`, `fl_code` and `data_out`, and its result does not depend on the codes of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; both edges capture stage codes |
| rst | input | 1 | Synchronous active-high reset |
| samp_vld | input | 1 | A valid analog sample is taken at this rising edge |
| stg_code | input | NCH*NSTG*2 | Stage codes; channel c, stage k sits at bits (c*NSTG+k)*2 +: 2 |
| fl_code | input | NCH*2 | Final flash code; channel c at bits c*2 +: 2 |
| data_out | output | NCH*(NSTG+1) | Corrected offset-binary words; channel c at bits c*8 +: 8 |
| data_vld | output | 1 | `data_out` carries a new word |

## Verification
If one stage's delay is off by a half or whole clock, its code gets merged with the wrong sample. That shows up as a wrong word 6 clocks after the first sample whose codes vary. With random codes it appears within a few samples, and each wrong bit position tells which weight, and so which stage, is misaligned. A clamp fault shows only in the full-scale and boundary blocks (sums of 0, 1, 256, 257 and above). A broken valid line shows as `data_vld` out of step with `samp_vld` 6 clocks earlier, or as `data_out` moving while `data_vld` is low.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  localparam int CODE_W = 2;

  // Stage k is captured k+1 half clocks after the sampling edge.
  function automatic bit cap_on_fall(input int k);
    return ((k + 1) % 2) == 1;
  endfunction

  // Rising edge (counted from the sample) on which every code of a sample is aligned.
  function automatic int align_tick(input int nstg);
    return (nstg + 2) / 2;
  endfunction

  // Sample-to-output latency: alignment, sum register, output register.
  function automatic int pipe_lat(input int nstg);
    return align_tick(nstg) + 2;
  endfunction

  // Number of rising-edge registers a stage code passes through.
  function automatic int align_depth(input int k, input int nstg);
    if (cap_on_fall(k)) return align_tick(nstg) - k / 2;
    return align_tick(nstg) - (k + 1) / 2 + 1;
  endfunction

endpackage

// File: rtl/adc_stage_delay.sv
module adc_stage_delay #(
  parameter int CW    = 2,
  parameter bit FALL  = 1'b0,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout
);

  logic [CW-1:0] entry;
  logic [CW-1:0] pipe [DEPTH];

  generate
    if (FALL) begin : g_fall
      logic [CW-1:0] neg_q;
      always_ff @(negedge clk) begin
        if (rst) neg_q <= '0;
        else     neg_q <= din;
      end
      assign entry = neg_q;
    end else begin : g_rise
      assign entry = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= entry;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/adc_ovl_merge.sv
module adc_ovl_merge #(
  parameter int NSTG  = 7,
  parameter int CW    = 2,
  parameter int OUT_W = NSTG + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [(NSTG+1)*CW-1:0] codes,
  input  logic                   load,
  output logic [OUT_W-1:0]       dout
);

  localparam int SUM_W = NSTG + 3;
  localparam int unsigned OFS  = (2**NSTG - 1) + 2 - 2**(OUT_W-1);
  localparam int unsigned MAXV = 2**OUT_W - 1;

  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] diff;
  logic [OUT_W-1:0] clip;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NSTG; k++) begin
      acc = acc + (SUM_W'(codes[k*CW +: CW]) << (NSTG - 1 - k));
    end
    acc = acc + SUM_W'(codes[NSTG*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= acc;
  end

  always_comb begin
    diff = sum_q - SUM_W'(OFS);
    if (sum_q < SUM_W'(OFS))      clip = '0;
    else if (diff > SUM_W'(MAXV)) clip = '1;
    else                          clip = diff[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= clip;
  end

endmodule

// File: rtl/adc_pipe_corr.sv
module adc_pipe_corr
  import adc_corr_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NSTG = 7,
  localparam int OUT_W = NSTG + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        samp_vld,
  input  logic [NCH*NSTG*CODE_W-1:0]  stg_code,
  input  logic [NCH*CODE_W-1:0]       fl_code,
  output logic [NCH*OUT_W-1:0]        data_out,
  output logic                        data_vld
);

  localparam int LAT = pipe_lat(NSTG);
  localparam int AW  = (NSTG + 1) * CODE_W;

  logic [LAT:0] vld_sr;

  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[LAT-1:0], samp_vld};
  end

  assign data_vld = vld_sr[LAT];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [AW-1:0] algn;

      for (genvar k = 0; k <= NSTG; k++) begin : g_stg
        logic [CODE_W-1:0] raw;
        if (k < NSTG) begin : g_mid
          assign raw = stg_code[(c*NSTG + k)*CODE_W +: CODE_W];
        end else begin : g_flash
          assign raw = fl_code[c*CODE_W +: CODE_W];
        end

        adc_stage_delay #(
          .CW   (CODE_W),
          .FALL (cap_on_fall(k)),
          .DEPTH(align_depth(k, NSTG))
        ) u_dly (
          .clk (clk),
          .rst (rst),
          .din (raw),
          .dout(algn[k*CODE_W +: CODE_W])
        );
      end

      adc_ovl_merge #(
        .NSTG (NSTG),
        .CW   (CODE_W),
        .OUT_W(OUT_W)
      ) u_mrg (
        .clk  (clk),
        .rst  (rst),
        .codes(algn),
        .load (vld_sr[LAT-1]),
        .dout (data_out[c*OUT_W +: OUT_W])
      );
    end
  endgenerate

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk
  import adc_corr_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NSTG = 7
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          samp_vld,
  input logic [NCH*NSTG*CODE_W-1:0]    stg_code,
  input logic [NCH*CODE_W-1:0]         fl_code,
  input logic [NCH*(NSTG+1)-1:0]       data_out,
  input logic                          data_vld
);

  localparam int LAT   = pipe_lat(NSTG);
  localparam int OUT_W = NSTG + 1;

  logic [LAT:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else     shadow <= {shadow[LAT-1:0], samp_vld};
  end

  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (rst)
    data_vld == shadow[LAT]); // R6

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (!data_vld && !$past(rst)) |-> $stable(data_out)); // R7

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!data_vld && data_out == '0)); // R8

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_mid
      logic is_mid;
      int   run;

      always_comb begin
        is_mid = samp_vld && (fl_code[c*CODE_W +: CODE_W] == 2'd2);
        for (int k = 0; k < NSTG; k++) begin
          if (stg_code[(c*NSTG + k)*CODE_W +: CODE_W] != 2'd1) is_mid = 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (rst || !is_mid) run <= 0;
        else if (run < LAT + 1) run <= run + 1;
      end

      AST_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        (run >= LAT + 1 && data_vld) |->
          data_out[c*OUT_W +: OUT_W] == OUT_W'(1 << (OUT_W - 1))); // R5
    end
  endgenerate

endmodule

bind adc_pipe_corr adc_corr_chk #(
  .NCH (NCH),
  .NSTG(NSTG)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .samp_vld(samp_vld),
  .stg_code(stg_code),
  .fl_code (fl_code),
  .data_out(data_out),
  .data_vld(data_vld)
);

// File: tb/sim_adc_pipe_corr.sv
module sim_adc_pipe_corr;

  localparam int NCH  = 2;
  localparam int NSTG = 7;
  localparam int OW   = NSTG + 1;
  localparam int LAT  = 6;
  localparam int NCYC = 600;

  logic                   clk = 1'b0;
  logic                   rst;
  logic                   samp_vld;
  logic [NCH*NSTG*2-1:0]  stg_code;
  logic [NCH*2-1:0]       fl_code;
  logic [NCH*OW-1:0]      data_out;
  logic                   data_vld;

  int scode [NCYC][NCH][NSTG];
  int fcode [NCYC][NCH];
  bit vin   [NCYC];
  bit rin   [NCYC];
  int exp_w [NCH];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_pipe_corr #(.NCH(NCH), .NSTG(NSTG)) u0 (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .stg_code(stg_code),
    .fl_code(fl_code), .data_out(data_out), .data_vld(data_vld)
  );

  function automatic int code_of(int n, int ch, int k);
    if (n < 0 || n >= NCYC) return 0;
    if (k == NSTG) return fcode[n][ch];
    return scode[n][ch][k];
  endfunction

  // R2, R4: expected word from the sample's codes
  function automatic int word_of(int n, int ch);
    int s = 0;
    for (int k = 0; k < NSTG; k++) s += scode[n][ch][k] << (NSTG - 1 - k);
    s = s + fcode[n][ch] - 1;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic put_code(int ch, int k, int v);
    if (k == NSTG) fl_code[ch*2 +: 2] = 2'(v);
    else stg_code[(ch*NSTG + k)*2 +: 2] = 2'(v);
  endtask

  // R1: codes captured on a falling edge, half a clock after rising edge c
  task automatic drive_fall(int c);
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k <= NSTG; k++)
        if (((k + 1) % 2) == 1) put_code(ch, k, code_of(c - k / 2, ch, k));
  endtask

  // R1: codes captured on rising edge c+1
  task automatic drive_rise(int c);
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k <= NSTG; k++)
        if (((k + 1) % 2) == 0) put_code(ch, k, code_of(c + 1 - (k + 1) / 2, ch, k));
    samp_vld = (c + 1 < NCYC) ? vin[c+1] : 1'b0;
    rst      = (c + 1 < NCYC) ? rin[c+1] : 1'b0;
  endtask

  task automatic fill(int n, int ch, int sv, int fv);
    for (int k = 0; k < NSTG; k++) scode[n][ch][k] = sv;
    fcode[n][ch] = fv;
  endtask

  task automatic check_cycle(int c);
    bit ok;
    bit rwin = 1'b0;
    string tag;
    for (int j = 0; j <= LAT; j++) if (c - j >= 0 && rin[c-j]) rwin = 1'b1;
    ok = (c >= LAT) && !rwin && vin[c-LAT];
    if (rin[c]) for (int ch = 0; ch < NCH; ch++) exp_w[ch] = 0;
    checks++;
    if (data_vld !== ok) begin
      errors++;
      $display("FAIL %s cyc=%0d data_vld got=%0b exp=%0b", rwin ? "R8" : "R6", c, data_vld, ok);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (ok) exp_w[ch] = word_of(c - LAT, ch);
      if (rin[c]) tag = "R8";
      else if (!ok) tag = "R7";
      else if (c - LAT >= 20 && c - LAT < 40) tag = "R5";
      else if (c - LAT >= 40 && c - LAT < 72) tag = "R4";
      else tag = (ch == 1) ? "R2/R3/R9" : "R1/R2/R3";
      checks++;
      if (data_out[ch*OW +: OW] !== OW'(exp_w[ch])) begin
        errors++;
        $display("FAIL %s cyc=%0d ch=%0d data_out got=%0h exp=%0h", tag, c, ch,
                 data_out[ch*OW +: OW], exp_w[ch]);
      end
    end
  endtask

  initial begin
    for (int n = 0; n < NCYC; n++) begin
      rin[n] = (n < 4) || (n == 150) || (n == 151);
      if (n < 4) vin[n] = 1'b0;
      else if (n < 72) vin[n] = 1'b1;
      else if (n < 200) vin[n] = ($urandom_range(9) < 7);
      else vin[n] = ($urandom_range(9) < 9);
      for (int ch = 0; ch < NCH; ch++) begin
        for (int k = 0; k < NSTG; k++) scode[n][ch][k] = $urandom_range(3);
        fcode[n][ch] = $urandom_range(3);
        if (n >= 20 && n < 40) fill(n, ch, 1, 2);      // R5 mid-scale
        else if (n >= 40 && n < 50) fill(n, ch, 0, 0); // R4 below zero
        else if (n >= 50 && n < 60) fill(n, ch, 2, 3); // R4 just over full scale
        else if (n >= 60 && n < 70) fill(n, ch, 3, 3); // R4 far over full scale
      end
    end
    // R4 boundaries: sum 256 -> 255, 255 -> 254, 1 -> 0, 2 -> 1
    fill(70, 0, 1, 1); scode[70][0][0] = 3;
    fill(70, 1, 1, 0); scode[70][1][0] = 3;
    fill(71, 0, 0, 1);
    fill(71, 1, 0, 2);
    for (int ch = 0; ch < NCH; ch++) exp_w[ch] = 0;

    rst = 1'b1; samp_vld = 1'b0; stg_code = '0; fl_code = '0;
    for (int c = 0; c < NCYC - 1; c++) begin
      @(posedge clk);
      #1 drive_fall(c);
      #2 check_cycle(c);
      @(negedge clk);
      #1 drive_rise(c);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule